// File: doc/BRIEF.md
# Two-Wire Bus Arbitration Monitor

This block sits beside the master engine of a two-wire serial bus controller and watches the synchronized clock and data samples. Whenever the local master drives a bit, it compares the level it meant to put on the line with the level actually seen on the bus at the clock rising edge. It flags lost arbitration only when the master wanted a high and another device pulled the line low. From that moment it releases the data line and tells the controller to fall back to slave reception so the incoming address can still be checked. Clocking may continue up to the end of the current packet and then stops.

The same block decodes START, repeated START and STOP conditions, tracks whether the bus is busy, and flags a bus error when a condition shows up in the middle of a packet. A start request from the controller is queued and only granted when the bus is free, so a request made during someone else's transfer waits for that transfer's STOP.

Top module: `i2c_arb_monitor`

## Requirements
- R1: `arb_lost_o` is a one-cycle pulse raised only in a cycle where SCL rises (low in the previous cycle, high now), `master_active_i`, `drive_phase_i` and `drive_sda_i` are all 1 and `sda_i` is 0; once raised it is not raised again until the next START or STOP.
- R2: A bit with `drive_sda_i`=0 and `sda_i`=1, or any bit with `drive_phase_i`=0 (such as the acknowledge slot at bit index 8), never raises `arb_lost_o`.
- R3: `sda_release_o` is 1 in the loss cycle and stays 1 until a START or STOP is detected; it is 0 otherwise.
- R4: After a loss, `clk_allow_o` stays 1 until SCL falls while `bit_idx_i` equals 8; from the next cycle it is 0 until a START or STOP is detected. Without a loss it is 1.
- R5: `slave_fallback_o` is 1 from the cycle after the loss until a START or STOP is detected.
- R6: The comparison keeps running across any number of packets; matching bits over several bytes raise nothing and a mismatch in a later byte is still caught.
- R7: START is SDA falling while SCL stays high, STOP is SDA rising while SCL stays high. A START on an idle bus pulses `start_det_o`, a START on a busy bus pulses `rstart_det_o`, and a STOP pulses `stop_det_o`, each in the cycle the edge is sampled; at most one of them is high.
- R8: `bus_busy_o` becomes 1 the cycle after a START and 0 the cycle after a STOP; it is 0 after reset.
- R9: `start_go_o` is 1 only while a request (current `start_req_i` or an earlier queued one) is pending, the bus is not busy and no START is being detected in that cycle; a request made while busy is held and granted in the cycle after the STOP.
- R10: `bus_err_o` pulses when a START or STOP is detected while the bus is busy and `bit_idx_i` is not 0.
- R11: During and right after reset every output is 0 except `clk_allow_o`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample |
| master_active_i | input | 1 | Local controller is acting as master |
| drive_sda_i | input | 1 | SDA level the local master intends to drive |
| drive_phase_i | input | 1 | Current bit is driven by the local master |
| bit_idx_i | input | 4 | Bit position in the packet, 0..7 data, 8 acknowledge |
| start_req_i | input | 1 | Request to issue a START |
| arb_lost_o | output | 1 | Arbitration lost pulse |
| sda_release_o | output | 1 | Stop driving SDA |
| clk_allow_o | output | 1 | Clock generation permitted |
| slave_fallback_o | output | 1 | Switch to slave address reception |
| start_det_o | output | 1 | START detected on idle bus |
| rstart_det_o | output | 1 | Repeated START detected |
| stop_det_o | output | 1 | STOP detected |
| bus_busy_o | output | 1 | Bus is held by some master |
| bus_err_o | output | 1 | Condition at an illegal bit position |
| start_go_o | output | 1 | Permission to issue the queued START |

## Verification
Two functions meet in one cycle when the controller raises a start request in the very cycle a foreign START is sampled: the grant logic must see the START and refuse, leaving the request queued until a later STOP. The bench provokes this by lining up `start_req_i` with the SDA falling edge of another master's START, and judges it by comparing the grant, busy and condition outputs against its reference model on every cycle. A second overlap, a condition arriving mid-packet while the busy flag is set, checks that the condition pulse and the bus error come out together.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  localparam int unsigned BIT_W    = 4;
  localparam int unsigned LAST_BIT = 8;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_evt_t;
endpackage

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_arb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o,
  output logic     busy_o
);
  logic scl_q, sda_q, busy_q;

  always_comb begin
    evt_o.rise  = scl_i & ~scl_q;
    evt_o.fall  = ~scl_i & scl_q;
    evt_o.start = scl_i & scl_q & sda_q & ~sda_i;
    evt_o.stop  = scl_i & scl_q & ~sda_q & sda_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (evt_o.start)     busy_q <= 1'b1;
      else if (evt_o.stop) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/i2c_arb_track.sv
module i2c_arb_track
  import i2c_arb_pkg::*;
#(
  parameter int unsigned IDX_W   = BIT_W,
  parameter int unsigned END_IDX = LAST_BIT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  bus_evt_t         evt_i,
  input  logic             sda_i,
  input  logic             master_active_i,
  input  logic             drive_sda_i,
  input  logic             drive_phase_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  output logic             lost_o,
  output logic             release_o,
  output logic             clk_allow_o,
  output logic             fallback_o
);
  localparam logic [IDX_W-1:0] EndIdx = IDX_W'(END_IDX);

  logic lost_q, done_q, mismatch, frame_evt;

  // only a driven high overridden by a low bus counts
  assign mismatch  = evt_i.rise & master_active_i & drive_phase_i
                   & drive_sda_i & ~sda_i & ~lost_q;
  assign frame_evt = evt_i.start | evt_i.stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lost_q <= 1'b0;
      done_q <= 1'b0;
    end else if (frame_evt) begin
      lost_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (mismatch) lost_q <= 1'b1;
      if (lost_q && evt_i.fall && bit_idx_i == EndIdx) done_q <= 1'b1;
    end
  end

  assign lost_o      = mismatch;
  assign release_o   = lost_q | mismatch;
  assign clk_allow_o = ~done_q;
  assign fallback_o  = lost_q;
endmodule

// File: rtl/i2c_start_gate.sv
module i2c_start_gate
  import i2c_arb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  bus_evt_t evt_i,
  input  logic     busy_i,
  input  logic     start_req_i,
  output logic     go_o
);
  logic pend_q, want;

  assign want = pend_q | start_req_i;
  assign go_o = want & ~busy_i & ~evt_i.start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= want & ~go_o;
  end
endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor
  import i2c_arb_pkg::*;
#(
  parameter int unsigned IDX_W   = BIT_W,
  parameter int unsigned END_IDX = LAST_BIT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             master_active_i,
  input  logic             drive_sda_i,
  input  logic             drive_phase_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             start_req_i,
  output logic             arb_lost_o,
  output logic             sda_release_o,
  output logic             clk_allow_o,
  output logic             slave_fallback_o,
  output logic             start_det_o,
  output logic             rstart_det_o,
  output logic             stop_det_o,
  output logic             bus_busy_o,
  output logic             bus_err_o,
  output logic             start_go_o
);
  bus_evt_t evt;
  logic     busy;

  i2c_cond_detect u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .evt_o  (evt),
    .busy_o (busy)
  );

  i2c_arb_track #(.IDX_W(IDX_W), .END_IDX(END_IDX)) u_arb (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .evt_i           (evt),
    .sda_i           (sda_i),
    .master_active_i (master_active_i),
    .drive_sda_i     (drive_sda_i),
    .drive_phase_i   (drive_phase_i),
    .bit_idx_i       (bit_idx_i),
    .lost_o          (arb_lost_o),
    .release_o       (sda_release_o),
    .clk_allow_o     (clk_allow_o),
    .fallback_o      (slave_fallback_o)
  );

  i2c_start_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .busy_i      (busy),
    .start_req_i (start_req_i),
    .go_o        (start_go_o)
  );

  assign start_det_o  = evt.start & ~busy;
  assign rstart_det_o = evt.start & busy;
  assign stop_det_o   = evt.stop;
  assign bus_busy_o   = busy;
  assign bus_err_o    = (evt.start | evt.stop) & busy & (bit_idx_i != '0);
endmodule

// File: rtl/i2c_arb_monitor_chk.sv
module i2c_arb_monitor_chk #(
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned END_IDX = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sda_i,
  input logic             drive_sda_i,
  input logic             drive_phase_i,
  input logic [IDX_W-1:0] bit_idx_i,
  input logic             arb_lost_o,
  input logic             sda_release_o,
  input logic             clk_allow_o,
  input logic             start_det_o,
  input logic             rstart_det_o,
  input logic             stop_det_o,
  input logic             bus_busy_o,
  input logic             start_go_o
);
  // R1
  lost_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_o |-> (drive_sda_i && drive_phase_i && !sda_i));
  // R1
  lost_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_o |=> !arb_lost_o);
  // R3
  release_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_o |=> sda_release_o);
  // R4
  clk_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_allow_o) |-> ($past(bit_idx_i) == IDX_W'(END_IDX) && $past(sda_release_o)));
  // R7
  cond_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_det_o, rstart_det_o, stop_det_o}));
  // R8
  busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det_o || rstart_det_o) |=> bus_busy_o);
  // R8
  busy_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_o |=> !bus_busy_o);
  // R9
  go_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_go_o |-> !bus_busy_o);
endmodule

bind i2c_arb_monitor i2c_arb_monitor_chk #(.IDX_W(IDX_W), .END_IDX(END_IDX)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sda_i         (sda_i),
  .drive_sda_i   (drive_sda_i),
  .drive_phase_i (drive_phase_i),
  .bit_idx_i     (bit_idx_i),
  .arb_lost_o    (arb_lost_o),
  .sda_release_o (sda_release_o),
  .clk_allow_o   (clk_allow_o),
  .start_det_o   (start_det_o),
  .rstart_det_o  (rstart_det_o),
  .stop_det_o    (stop_det_o),
  .bus_busy_o    (bus_busy_o),
  .start_go_o    (start_go_o)
);

// File: tb/tb_i2c_arb_monitor.sv
`timescale 1ns/1ps
module tb_i2c_arb_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, mact = 1'b0, drv = 1'b1, phase = 1'b0, req = 1'b0;
  logic [3:0] bidx = 4'd0;
  logic arb_lost, rel, clk_ok, fb, st_det, rst_det, sp_det, busy, err, go;

  int checks = 0, errors = 0, lost_cnt = 0, go_cnt = 0;
  bit done = 0;

  // reference state
  bit p_scl = 1, p_sda = 1, m_busy = 0, m_lost = 0, m_done = 0, m_pend = 0;

  always #2 clk = ~clk;

  i2c_arb_monitor dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .master_active_i(mact), .drive_sda_i(drv), .drive_phase_i(phase),
    .bit_idx_i(bidx), .start_req_i(req),
    .arb_lost_o(arb_lost), .sda_release_o(rel), .clk_allow_o(clk_ok),
    .slave_fallback_o(fb), .start_det_o(st_det), .rstart_det_o(rst_det),
    .stop_det_o(sp_det), .bus_busy_o(busy), .bus_err_o(err), .start_go_o(go)
  );

  task automatic cmp(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: evaluate model against outputs, then advance on posedge
  task automatic step();
    bit rise, fall, st, sp, mis, e_go;
    #1;
    rise = scl && !p_scl;
    fall = !scl && p_scl;
    st   = scl && p_scl && p_sda && !sda;
    sp   = scl && p_scl && !p_sda && sda;
    mis  = rise && mact && phase && drv && !sda && !m_lost;
    e_go = (m_pend || req) && !m_busy && !st;
    cmp("R1 arb_lost", arb_lost, mis);
    cmp("R3 sda_release", rel, m_lost || mis);
    cmp("R4 clk_allow", clk_ok, !m_done);
    cmp("R5 slave_fallback", fb, m_lost);
    cmp("R7 start_det", st_det, st && !m_busy);
    cmp("R7 rstart_det", rst_det, st && m_busy);
    cmp("R7 stop_det", sp_det, sp);
    cmp("R8 bus_busy", busy, m_busy);
    cmp("R10 bus_err", err, (st || sp) && m_busy && bidx != 0);
    cmp("R9 start_go", go, e_go);
    if (arb_lost) lost_cnt++;
    if (go) go_cnt++;
    @(posedge clk);
    if (st || sp) begin m_lost = 0; m_done = 0; end
    else begin
      if (m_lost && fall && bidx == 8) m_done = 1;
      if (mis) m_lost = 1;
    end
    if (st) m_busy = 1; else if (sp) m_busy = 0;
    m_pend = (m_pend || req) && !e_go;
    p_scl = scl; p_sda = sda;
    @(negedge clk);
  endtask

  task automatic tbit(input logic b, input logic d, input logic ph, input int idx);
    scl = 0; sda = b; drv = d; phase = ph; bidx = 4'(idx); step();
    scl = 1; step(); step();
    scl = 0; step();
  endtask

  task automatic tbyte(input logic [7:0] bus_v, input logic [7:0] drv_v, input logic ack);
    for (int i = 0; i < 8; i++) tbit(bus_v[7-i], drv_v[7-i], 1'b1, i);
    tbit(ack, 1'b1, 1'b0, 8);
  endtask

  task automatic tstart(input int idx);
    bidx = 4'(idx); phase = 0;
    scl = 0; sda = 1; step();
    scl = 1; step();
    sda = 0; step();
    scl = 0; step();
  endtask

  task automatic tstop(input int idx);
    bidx = 4'(idx); phase = 0;
    scl = 0; sda = 0; step();
    scl = 1; step();
    sda = 1; step();
    step();
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); #1;
    // R11 reset state
    cmp("R11 reset arb_lost", arb_lost, 0);
    cmp("R11 reset release", rel, 0);
    cmp("R11 reset clk_allow", clk_ok, 1);
    cmp("R11 reset busy", busy, 0);
    cmp("R11 reset go", go, 0);
    @(negedge clk); rst_n = 1;
    step();

    // own transfer: request on idle bus is granted at once (R9)
    mact = 1; req = 1; step(); req = 0;
    tstart(0);
    // matching bytes, acknowledge slot with driven high vs low bus (R2, R6)
    tbyte(8'hA4, 8'hA4, 1'b0);
    tbyte(8'h0F, 8'h00, 1'b0);
    checks++;
    if (lost_cnt != 0) begin errors++; $display("FAIL R2/R6: actual %0d losses expected 0", lost_cnt); end
    // third byte loses on bit index 2 (R6)
    tbyte(8'hD0, 8'hF0, 1'b0);
    checks++;
    if (lost_cnt != 1) begin errors++; $display("FAIL R6: actual %0d losses expected 1", lost_cnt); end
    cmp("R4 clock stopped after packet", clk_ok, 0);
    cmp("R5 fallback held", fb, 1);
    cmp("R3 release held", rel, 1);
    tstop(0);
    cmp("R3 release cleared by STOP", rel, 0);
    cmp("R8 idle after STOP", busy, 0);

    // foreign transfer, request arrives on the START edge cycle (R9)
    mact = 0;
    bidx = 0; scl = 1; sda = 1; step();
    sda = 0; req = 1; step(); req = 0;
    cmp("R9 no grant on START edge", go, 0);
    go_cnt = 0;
    scl = 0; step();
    tbyte(8'h3C, 8'hFF, 1'b1);
    cmp("R9 still waiting while busy", go_cnt[0], 0);
    // legal repeated START at index 0, then illegal one at index 3 (R7, R10)
    tstart(0);
    for (int i = 0; i < 3; i++) tbit(1'b1, 1'b1, 1'b0, i);
    tstart(3);
    tbit(1'b0, 1'b1, 1'b0, 4);
    tstop(4);
    step();
    cmp("R9 granted once after STOP", go_cnt == 1, 1);
    tstop(0);
    repeat (4) step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule